// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers 64 interrupt request lines into one interrupt output for a single processor. The lines fall into two banks of 32. Each bank keeps three kinds of state: latched edge events, an enable mask, and the live input levels. Each bank also has a fixed set of bits that are treated as level-triggered. Edge sources and level sources live side by side in the same bank. An edge source latches an event when its synchronized input rises. A level source never latches an event and is pending for as long as its input is high.

Software reaches the banks through a small 32-bit register bus that decodes a 4 KiB window. Software can read the events, the mask and the live levels, can write the mask, and acknowledges events with write-one-to-clear. The output is high whenever any enabled source in either bank is pending.

Top module: `dual_bank_irqc`

## Requirements
- R1: After reset the events, mask and level registers of both banks read zero, `irq_out` is low and `bus_rdata` is zero.
- R2: The bank index is (addr[11:0] − 0x010) >> 4. Index 0 selects bank 0 (offsets 0x010–0x01F) and index 1 selects bank 1 (0x020–0x02F). Any other index reads zero, and writes to it change nothing.
- R3: Within a bank, addr[3:0] selects the register. 0x0 returns the events, 0x4 is the read/write mask, 0x8 is the acknowledge (writes only, reads zero) and 0xC returns the levels. Every other nibble reads zero, and writes to it change nothing.
- R4: Input line n in 0–31 maps to bank 1, bit n. Input line n in 32–63 maps to bank 0, bit n−32.
- R5: Each input passes through two synchronizer flops. The level bit follows the synchronized input. A rising edge of the synchronized input sets the event bit of an edge-configured source. A falling edge clears only the level bit and leaves a latched event set. An input held high does not latch a new event after an acknowledge.
- R6: A level-configured bit never appears in the events register, and an acknowledge has no effect on it. It is pending while its level bit is 1.
- R7: Writing the acknowledge register clears every edge-configured event bit written as 1. Bits written as 0 are unchanged.
- R8: If a rising edge and an acknowledge of the same bit land in the same cycle, the event bit stays set.
- R9: A bank is pending when ((events | (levels & level_cfg)) & mask) is nonzero. `irq_out` is high if either bank is pending. `irq_out` is registered, so it reflects the state one cycle after that state changes.
- R10: A read issued on a clock edge with `bus_valid` high and `bus_write` low returns its data on `bus_rdata` after that edge. `bus_rdata` holds its value until the next read.
- R11: The level configuration is fixed: 0x00000000 for bank 0 and 0x1FF00000 (bits 20–28) for bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| irq_in | input | 64 | Asynchronous interrupt request lines |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the read edge |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
A corrupted event latch shows up on `bus_rdata` at the first read of the affected bank's event offset. If the source is enabled, `irq_out` also goes wrong one cycle after the bad state appears. A wrong decode or a wrong input-to-bank mapping shows at once as a nonzero read at an address that should be empty, or as the bit appearing in the wrong bank. A fault in how an acknowledge and an edge are ordered shows only in the single cycle where both strike the same bit, so the bench lines up that collision exactly.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BANK_W    = 32;
  localparam int unsigned SEL_W     = 4;

  typedef logic [BANK_W-1:0] word_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_EVENTS = 4'h0,
    SEL_MASK   = 4'h4,
    SEL_ACK    = 4'h8,
    SEL_LEVELS = 4'hC
  } reg_sel_e;

  typedef struct packed {
    word_t events;
    word_t mask;
    word_t levels;
  } bank_state_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      stage_q <= '0;
    end else begin
      meta_q  <= async_in;
      stage_q <= meta_q;
    end
  end

  assign sync_out = stage_q;
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter word_t LVL_CFG = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  word_t       lvl_in,
  input  logic        mask_we,
  input  logic        ack_we,
  input  word_t       wdata,
  output bank_state_t state,
  output logic        pending
);
  word_t events_q, events_d;
  word_t mask_q,   mask_d;
  word_t levels_q, levels_d;
  word_t rise;
  word_t ack_clr;

  // next-state
  always_comb begin
    rise     = lvl_in & ~levels_q;
    ack_clr  = ack_we ? (wdata & ~LVL_CFG) : '0;
    // a fresh edge outranks a same-cycle acknowledge
    events_d = (events_q & ~ack_clr) | (rise & ~LVL_CFG);
    mask_d   = wdata;
    levels_d = lvl_in;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      events_q <= '0;
      levels_q <= '0;
    end else begin
      events_q <= events_d;
      levels_q <= levels_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_d;
    end
  end

  assign state.events = events_q;
  assign state.mask   = mask_q;
  assign state.levels = levels_q;
  assign pending      = |((events_q | (levels_q & LVL_CFG)) & mask_q);
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int unsigned  NBANKS   = 2,
  parameter int unsigned  ADDR_W   = 12,
  parameter logic [11:0]  BASE_OFF = 12'h010
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  bank_state_t [NBANKS-1:0] st,
  output logic [NBANKS-1:0]        mask_we,
  output logic [NBANKS-1:0]        ack_we,
  output word_t                    rdata
);
  localparam int unsigned IDX_W = ADDR_W - SEL_W;

  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;
  logic [SEL_W-1:0]  sel;
  logic              hit;
  logic              rd_en;
  logic              wr_en;
  word_t             rdata_d;
  word_t             rdata_q;

  always_comb begin
    rel   = bus_addr - ADDR_W'(BASE_OFF);
    idx   = rel[ADDR_W-1:SEL_W];
    sel   = rel[SEL_W-1:0];
    hit   = (32'(idx) < NBANKS);
    rd_en = bus_valid && !bus_write;
    wr_en = bus_valid && bus_write && hit;
  end

  // write strobes
  always_comb begin
    mask_we = '0;
    ack_we  = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (wr_en && (32'(idx) == b)) begin
        mask_we[b] = (sel == SEL_MASK);
        ack_we[b]  = (sel == SEL_ACK);
      end
    end
  end

  // read mux
  always_comb begin
    rdata_d = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (hit && (32'(idx) == b)) begin
        unique case (sel)
          SEL_EVENTS: rdata_d = st[b].events;
          SEL_MASK:   rdata_d = st[b].mask;
          SEL_LEVELS: rdata_d = st[b].levels;
          default:    rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dual_bank_irqc.sv
module dual_bank_irqc
  import irqc_pkg::*;
#(
  parameter int unsigned             NBANKS    = 2,
  parameter int unsigned             ADDR_W    = 12,
  parameter logic [11:0]             BASE_OFF  = 12'h010,
  parameter logic [NBANKS*BANK_W-1:0] LEVEL_CFG = {32'h1FF0_0000, 32'h0000_0000}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NBANKS*BANK_W-1:0] irq_in,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [BANK_W-1:0]        bus_wdata,
  output logic [BANK_W-1:0]        bus_rdata,
  output logic                     irq_out
);
  localparam int unsigned NIRQ = NBANKS * BANK_W;

  logic [NIRQ-1:0]          irq_sync;
  bank_state_t [NBANKS-1:0] bank_st;
  logic [NBANKS-1:0]        bank_pend;
  logic [NBANKS-1:0]        mask_we;
  logic [NBANKS-1:0]        ack_we;
  logic                     irq_d;
  logic                     irq_q;

  irqc_sync #(.W(NIRQ)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_in),
    .sync_out (irq_sync)
  );

  // line group g lands in bank NBANKS-1-g
  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    irqc_bank #(.LVL_CFG(LEVEL_CFG[b*BANK_W +: BANK_W])) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_in  (irq_sync[(NBANKS-1-b)*BANK_W +: BANK_W]),
      .mask_we (mask_we[b]),
      .ack_we  (ack_we[b]),
      .wdata   (bus_wdata),
      .state   (bank_st[b]),
      .pending (bank_pend[b])
    );
  end

  irqc_regif #(
    .NBANKS   (NBANKS),
    .ADDR_W   (ADDR_W),
    .BASE_OFF (BASE_OFF)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .st        (bank_st),
    .mask_we   (mask_we),
    .ack_we    (ack_we),
    .rdata     (bus_rdata)
  );

  always_comb irq_d = |bank_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/dual_bank_irqc_chk.sv
module dual_bank_irqc_chk
  import irqc_pkg::*;
#(
  parameter int unsigned              NBANKS    = 2,
  parameter logic [NBANKS*BANK_W-1:0] LEVEL_CFG = '0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_valid,
  input logic                     bus_write,
  input logic [BANK_W-1:0]        bus_rdata,
  input logic                     irq_out,
  input bank_state_t [NBANKS-1:0] st
);
  logic any_mask;

  always_comb begin
    any_mask = 1'b0;
    for (int b = 0; b < NBANKS; b++) any_mask = any_mask | (|st[b].mask);
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_chk
    assert_lvl_no_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st[b].events & LEVEL_CFG[b*BANK_W +: BANK_W]) == '0);

    assert_mask_only_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write) |=> $stable(st[b].mask));

    assert_event_needs_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((st[b].events & ~$past(st[b].events) & ~st[b].levels) == '0));
  end

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_mask |=> !irq_out);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

bind dual_bank_irqc dual_bank_irqc_chk #(
  .NBANKS    (NBANKS),
  .LEVEL_CFG (LEVEL_CFG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .st        (bank_st)
);

// File: tb/dual_bank_irqc_bench.sv
`timescale 1ns/1ps
module dual_bank_irqc_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq_in;
  logic        bus_valid;
  logic        bus_write;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  sb_item_t sb_q[$];
  logic     rd_seen;

  always #2.5 clk = ~clk;

  dual_bank_irqc u_dual_bank_irqc (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_rd(logic [11:0] a, logic [31:0] exp, string req);
    sb_item_t it;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  // monitor: a read accepted at a posedge is compared at the next negedge
  always @(posedge clk) rd_seen <= rst_n && bus_valid && !bus_write;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        check("R10 unexpected read", 32'hx, 32'h0);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(it.req, bus_rdata, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    bus_rd(12'h010, 32'h0, "R1 bank0 events");
    bus_rd(12'h014, 32'h0, "R1 bank0 mask");
    bus_rd(12'h01C, 32'h0, "R1 bank0 levels");
    bus_rd(12'h020, 32'h0, "R1 bank1 events");
    bus_rd(12'h024, 32'h0, "R1 bank1 mask");
    bus_rd(12'h02C, 32'h0, "R1 bank1 levels");

    // R4/R5 edge line 40 -> bank0 bit 8
    @(negedge clk); irq_in[40] = 1'b1;
    idle(5);
    bus_rd(12'h010, 32'h0000_0100, "R4 R5 line40 event in bank0");
    bus_rd(12'h01C, 32'h0000_0100, "R5 line40 level");
    bus_rd(12'h020, 32'h0, "R4 bank1 untouched by line40");
    check("R9 masked edge quiet", {31'b0, irq_out}, 32'h0);
    @(negedge clk); irq_in[40] = 1'b0;
    idle(5);
    bus_rd(12'h01C, 32'h0, "R5 level cleared on fall");
    bus_rd(12'h010, 32'h0000_0100, "R5 event kept after fall");

    // R3/R9 mask write and output latency
    bus_wr(12'h014, 32'h0000_0100);
    check("R9 irq one cycle after mask", {31'b0, irq_out}, 32'h0);
    idle(1);
    check("R9 irq raised", {31'b0, irq_out}, 32'h1);
    bus_rd(12'h014, 32'h0000_0100, "R3 mask readback");

    // R7 acknowledge
    bus_wr(12'h018, 32'h0000_0100);
    idle(2);
    check("R7 irq dropped after ack", {31'b0, irq_out}, 32'h0);
    bus_rd(12'h010, 32'h0, "R7 event cleared");

    // R6/R11 level source line 20 -> bank1 bit 20
    @(negedge clk); irq_in[20] = 1'b1;
    idle(5);
    bus_rd(12'h02C, 32'h0010_0000, "R4 R11 line20 level in bank1");
    bus_rd(12'h020, 32'h0, "R6 level bit not latched");
    bus_wr(12'h024, 32'h0010_0000);
    idle(2);
    check("R9 level pending", {31'b0, irq_out}, 32'h1);
    bus_wr(12'h028, 32'hFFFF_FFFF);
    idle(2);
    check("R6 ack ignores level bit", {31'b0, irq_out}, 32'h1);
    @(negedge clk); irq_in[20] = 1'b0;
    idle(5);
    check("R9 level release drops irq", {31'b0, irq_out}, 32'h0);

    // R8 edge and acknowledge in the same cycle, line 3 -> bank1 bit 3
    @(negedge clk); irq_in[3] = 1'b1;
    idle(5);
    @(negedge clk); irq_in[3] = 1'b0;
    idle(5);
    bus_rd(12'h020, 32'h0000_0008, "R5 line3 event");
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk);
    bus_wr(12'h028, 32'h0000_0008);
    idle(3);
    bus_rd(12'h020, 32'h0000_0008, "R8 edge beats ack");
    bus_wr(12'h028, 32'h0000_0008);
    idle(3);
    bus_rd(12'h020, 32'h0, "R5 held input no relatch");

    // R2/R3 decode
    bus_wr(12'h034, 32'hFFFF_FFFF);
    bus_rd(12'h034, 32'h0, "R2 index 2 reads zero");
    bus_rd(12'h014, 32'h0000_0100, "R2 bank0 mask untouched");
    bus_rd(12'h024, 32'h0010_0000, "R2 bank1 mask untouched");
    bus_rd(12'h004, 32'h0, "R2 below window reads zero");
    bus_wr(12'h016, 32'hFFFF_FFFF);
    bus_rd(12'h014, 32'h0000_0100, "R3 unlisted offset write ignored");
    bus_rd(12'h018, 32'h0, "R3 ack reads zero");
    bus_rd(12'h011, 32'h0, "R3 unlisted offset reads zero");

    // R11 fixed level configuration of bank1
    @(negedge clk); irq_in[31:0] = 32'hFFFF_FFFF;
    idle(5);
    bus_rd(12'h020, 32'hE00F_FFF7, "R11 bank1 level bits never latch");
    bus_rd(12'h02C, 32'hFFFF_FFFF, "R11 bank1 levels");
    @(negedge clk); irq_in[63:32] = 32'hFFFF_FFFF;
    idle(5);
    bus_rd(12'h010, 32'hFFFF_FFFF, "R11 bank0 all edge");

    idle(2);
    if (sb_q.size() != 0) check("R10 reads left unanswered", sb_q.size(), 32'h0);
    finish_run();
  end
endmodule